// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block supervises software by counting slow ticks and demanding a periodic feed. When the count reaches the selected timeout, it asserts a one-cycle system reset request, raises a timeout flag and starts the count again from zero. A 4-bit period code selects the timeout. A warning flag can be raised partway through the period so that software gets a last chance to feed. A window check can flag a feed that arrives too early, which catches runaway code that feeds in a tight loop.

A feed comes either from a register write or from a rising edge on an external event input. A configuration bit selects which of the two is used. A lock bit freezes the whole configuration until the next reset. A reset-disable bit keeps the timeout flag but suppresses the reset request. A debug-halt input can stop the count while a debugger holds the core. Three sticky interrupt flags, an enable mask and separate set and clear write addresses drive a single interrupt line. The counter advances only on cycles where the tick-enable input is high, so the block runs from the fast clock while counting a slower time base.

Top module: `guard_timer`

## Requirements
- R1: With period code n (config bits 7:4) and the enable bit (config bit 0) set, the count (read at address 6) rises by one on each cycle with tickEn high and holds on other cycles. The tick that would take it past 2^(n+3) wraps it to zero instead, so a timeout happens every 2^(n+3)+1 ticks: 9 ticks for code 0 and 17 for code 1.
- R2: A timeout sets flag bit 0 (flags read at address 2). It also drives rstReqOut high for exactly one cycle, starting at the clock edge of the timeout tick. When the reset-disable bit (config bit 3) is set, the flag is still set but rstReqOut stays low.
- R3: Warning select w (config bits 9:8) of 1, 2 or 3 sets flag bit 1 on the tick where the count reaches floor(T/4), floor(T/2) or floor(3T/4), where T is the timeout. With w = 0 the warning flag is never set.
- R4: Window select k (config bits 12:10) of 1 to 7 sets flag bit 2 when a feed arrives while the count is below floor(k*T/8). Such a feed still clears the count. With k = 0 no feed sets this flag.
- R5: With the clear-source bit (config bit 2) at 0, writing 1 to bit 0 of address 1 clears the count and a rising edge on evtIn has no effect. With the bit at 1, a rising edge on evtIn clears the count and the register write has no effect.
- R6: Writing a 1 to the lock bit (config bit 13) freezes every config field: later config writes are ignored and the config readback at address 0 is unchanged. Only rstN clears the lock.
- R7: While dbgHalt is high and the debug-run bit (config bit 1) is 0, the count holds even with tickEn high. With the debug-run bit at 1, the count keeps advancing.
- R8: Flags stay set until a 1 is written to their bit at the clear address 4. Writing a 1 to a bit at address 3 sets that flag. The interrupt enable register is at address 5. irqOut is the OR of flags ANDed with the enables. A flag set event in the same cycle as a clear write leaves the flag set.
- R9: After reset the enable bit is 0, the period code is 15, all other config fields, flags and enables are 0, and the outputs are low. While the enable bit is 0 the count reads zero whatever tickEn does.
- R10: A feed in the same cycle as the timeout tick wins: the count goes to zero with no timeout flag and no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Count-advance qualifier (slow time base) |
| dbgHalt | input | 1 | Debugger holds the core |
| evtIn | input | 1 | External feed event, rising edge used |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for write and read |
| regWrData | input | 14 | Register write data |
| regRdData | output | 19 | Register read data for regAddr (combinational) |
| irqOut | output | 1 | Interrupt request |
| rstReqOut | output | 1 | One-cycle system reset request |

## Verification
The two collisions of interest are a flag-set event against a clear write, and a feed against the timeout tick. To provoke the first, the bench brings the count to the last value before timeout. It then drives tickEn together with a clear write to the timeout flag in the same cycle, and expects the flag to read back as set. For the second it drives tickEn together with a feed write at the same count, and expects a zero count, a clean flag register and rstReqOut low in the following cycle. The window check is also driven on both sides of its threshold, one count apart.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int CFG_W = 14;
  localparam int NUM_FLAGS = 3;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_FEED = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_FSET = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_FCLR = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_IEN  = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd6;

  // packed order matches the config register bit layout
  typedef struct packed {
    logic       lock;     // 13
    logic [2:0] winSel;   // 12:10
    logic [1:0] warnSel;  // 9:8
    logic [3:0] perSel;   // 7:4
    logic       rstDis;   // 3
    logic       clrSrc;   // 2
    logic       dbgRun;   // 1
    logic       en;       // 0
  } cfg_t;

  localparam cfg_t CFG_RST = cfg_t'(14'h00F0);

  typedef struct packed {
    logic feed;
    logic advance;
  } strobe_t;

  typedef struct packed {
    logic window;
    logic warn;
    logic timeout;
  } event_t;
endpackage

// File: rtl/guard_datapath.sv
module guard_datapath
  import guard_pkg::*;
#(
  parameter int CntW = 19
) (
  input  logic            clk,
  input  logic            rstN,
  input  cfg_t            cfg,
  input  strobe_t         strb,
  output logic [CntW-1:0] count,
  output event_t          evts
);
  localparam int WinW = 3;

  logic [CntW-1:0] lastCnt, fullCnt, eighth, warnThr, winThr, nextCnt;
  logic [CntW-1:0] winPart [WinW];
  logic            wrapNow, running;

  assign lastCnt = {{(CntW-1){1'b0}}, 1'b1} << ({1'b0, cfg.perSel} + 5'd3);
  assign fullCnt = lastCnt + 1'b1;
  assign eighth  = fullCnt >> 3;
  assign nextCnt = count + 1'b1;
  assign running = cfg.en && strb.advance && !strb.feed;
  assign wrapNow = running && (count >= lastCnt);

  always_comb begin
    unique case (cfg.warnSel)
      2'd1:    warnThr = fullCnt >> 2;
      2'd2:    warnThr = fullCnt >> 1;
      2'd3:    warnThr = (fullCnt >> 1) + (fullCnt >> 2);
      default: warnThr = '0;
    endcase
  end

  // k/8 of the timeout as a sum of shifted eighths
  for (genvar i = 0; i < WinW; i++) begin : g_winPart
    assign winPart[i] = cfg.winSel[i] ? (eighth << i) : '0;
  end

  always_comb begin
    winThr = '0;
    for (int i = 0; i < WinW; i++) winThr = winThr + winPart[i];
  end

  assign evts.timeout = wrapNow;
  assign evts.warn    = running && !wrapNow && (cfg.warnSel != 2'd0) && (nextCnt == warnThr);
  assign evts.window  = cfg.en && strb.feed && (cfg.winSel != 3'd0) && (count < winThr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                count <= '0;
    else if (!cfg.en)         count <= '0;
    else if (strb.feed)       count <= '0;
    else if (wrapNow)         count <= '0;
    else if (strb.advance)    count <= nextCnt;
  end

  assert_hold_disabled_R9: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.en |=> (count == '0));
  assert_hold_no_tick_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.en && !strb.advance && !strb.feed) |=> $stable(count));
  assert_feed_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.en && strb.feed) |=> (count == '0));
endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import guard_pkg::*;
#(
  parameter int CntW = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              dbgHalt,
  input  logic              evtIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  wrData,
  input  logic [CntW-1:0]   count,
  input  event_t            evts,
  output cfg_t              cfg,
  output strobe_t           strb,
  output logic [CntW-1:0]   rdData,
  output logic              irq,
  output logic              rstReq
);
  logic [NUM_FLAGS-1:0] flagsQ, ienQ, setVec, clrVec;
  logic                 evtQ, swFeed, evtRise;

  assign swFeed  = wrEn && (addr == ADDR_FEED) && wrData[0];
  assign evtRise = evtIn && !evtQ;
  assign strb.feed    = cfg.clrSrc ? evtRise : swFeed;
  assign strb.advance = tickEn && !(dbgHalt && !cfg.dbgRun);

  assign setVec = evts | ((wrEn && addr == ADDR_FSET) ? wrData[NUM_FLAGS-1:0] : '0);
  assign clrVec = (wrEn && addr == ADDR_FCLR) ? wrData[NUM_FLAGS-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg    <= CFG_RST;
      flagsQ <= '0;
      ienQ   <= '0;
      evtQ   <= 1'b0;
      rstReq <= 1'b0;
    end else begin
      evtQ   <= evtIn;
      flagsQ <= (flagsQ & ~clrVec) | setVec;
      rstReq <= evts.timeout && !cfg.rstDis;
      if (wrEn && addr == ADDR_CFG && !cfg.lock) cfg <= cfg_t'(wrData);
      if (wrEn && addr == ADDR_IEN) ienQ <= wrData[NUM_FLAGS-1:0];
    end
  end

  assign irq = |(flagsQ & ienQ);

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_CFG:  rdData = CntW'(cfg);
      ADDR_FLAG: rdData = CntW'(flagsQ);
      ADDR_IEN:  rdData = CntW'(ienQ);
      ADDR_CNT:  rdData = count;
      default:   rdData = '0;
    endcase
  end

  assert_rst_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);
  assert_rst_disabled_R2: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> !$past(cfg.rstDis));
  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfg.lock |=> (cfg.lock && $stable(cfg)));
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    evts.timeout |=> flagsQ[0]);
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_pkg::*;
#(
  parameter int CntW = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              dbgHalt,
  input  logic              evtIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CFG_W-1:0]  regWrData,
  output logic [CntW-1:0]   regRdData,
  output logic              irqOut,
  output logic              rstReqOut
);
  cfg_t            cfg;
  strobe_t         strb;
  event_t          evts;
  logic [CntW-1:0] count;

  guard_ctrl #(.CntW(CntW)) i_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .dbgHalt(dbgHalt), .evtIn(evtIn),
    .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData), .count(count),
    .evts(evts), .cfg(cfg), .strb(strb), .rdData(regRdData), .irq(irqOut),
    .rstReq(rstReqOut)
  );

  guard_datapath #(.CntW(CntW)) i_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb), .count(count), .evts(evts)
  );
endmodule

// File: tb/test_guard_timer.sv
module test_guard_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0, dbgHalt = 1'b0, evtIn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [13:0] regWrData = '0;
  logic [18:0] regRdData;
  logic        irqOut, rstReqOut;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  guard_timer i_guard_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .dbgHalt(dbgHalt), .evtIn(evtIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut), .rstReqOut(rstReqOut)
  );

  function automatic logic [13:0] mk(bit en, bit dbgRun, bit clrSrc, bit rstDis,
                                     int per, int warn, int win, bit lock);
    return {lock, 3'(win), 2'(warn), 4'(per), rstDis, clrSrc, dbgRun, en};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic [2:0] a, logic [13:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [2:0] a, output logic [31:0] v);
    regAddr = a; #1; v = 32'(regRdData);
  endtask

  task automatic ticks(int n);
    @(negedge clk); tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic setCfg(logic [13:0] c);
    wrReg(3'd0, 14'd0);
    wrReg(3'd4, 14'h7);
    wrReg(3'd0, c);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rdReg(3'd0, v); check("R9 cfg reset", v, 32'h0F0);
    rdReg(3'd2, v); check("R9 flags reset", v, 0);
    rdReg(3'd5, v); check("R9 ien reset", v, 0);
    check("R9 outputs reset", {irqOut, rstReqOut}, 0);
    ticks(5);
    rdReg(3'd6, v); check("R9 disabled count", v, 0);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    setCfg(mk(1,0,0,0,0,0,0,0));
    ticks(8);
    rdReg(3'd6, v); check("R1 count before wrap", v, 8);
    check("R2 no reset yet", rstReqOut, 0);
    ticks(1);
    check("R2 reset pulse", rstReqOut, 1);
    rdReg(3'd6, v); check("R1 wrap to zero", v, 0);
    rdReg(3'd2, v); check("R2 timeout flag", v, 1);
    @(negedge clk); check("R2 pulse one cycle", rstReqOut, 0);
    setCfg(mk(1,0,0,0,1,0,0,0));
    ticks(16);
    check("R1 code1 no reset at 16", rstReqOut, 0);
    ticks(1);
    check("R1 code1 reset at 17", rstReqOut, 1);
  endtask

  task automatic t_rstDis();
    logic [31:0] v;
    setCfg(mk(1,0,0,1,0,0,0,0));
    ticks(9);
    check("R2 reset suppressed", rstReqOut, 0);
    rdReg(3'd2, v); check("R2 flag with reset disabled", v, 1);
  endtask

  task automatic t_warn();
    logic [31:0] v;
    setCfg(mk(1,0,0,0,1,3,0,0));
    ticks(11);
    rdReg(3'd2, v); check("R3 75pct not yet", v, 0);
    ticks(1);
    rdReg(3'd2, v); check("R3 75pct at 12", v, 2);
    setCfg(mk(1,0,0,0,0,1,0,0));
    ticks(1);
    rdReg(3'd2, v); check("R3 25pct not yet", v, 0);
    ticks(1);
    rdReg(3'd2, v); check("R3 25pct at 2", v, 2);
    setCfg(mk(1,0,0,0,0,0,0,0));
    ticks(8);
    rdReg(3'd2, v); check("R3 warning disabled", v, 0);
  endtask

  task automatic t_window();
    logic [31:0] v;
    setCfg(mk(1,0,0,0,0,0,4,0));
    ticks(3);
    wrReg(3'd1, 14'h1);
    rdReg(3'd2, v); check("R4 early feed flagged", v, 4);
    rdReg(3'd6, v); check("R4 early feed clears count", v, 0);
    wrReg(3'd4, 14'h7);
    ticks(4);
    wrReg(3'd1, 14'h1);
    rdReg(3'd2, v); check("R4 feed at threshold ok", v, 0);
  endtask

  task automatic t_clrSrc();
    logic [31:0] v;
    setCfg(mk(1,0,1,0,15,0,0,0));
    ticks(3);
    wrReg(3'd1, 14'h1);
    rdReg(3'd6, v); check("R5 write ignored with event source", v, 3);
    @(negedge clk); evtIn = 1'b1;
    @(negedge clk); evtIn = 1'b0;
    rdReg(3'd6, v); check("R5 event edge clears", v, 0);
    setCfg(mk(1,0,0,0,15,0,0,0));
    ticks(3);
    @(negedge clk); evtIn = 1'b1;
    @(negedge clk); evtIn = 1'b0;
    rdReg(3'd6, v); check("R5 event ignored with write source", v, 3);
  endtask

  task automatic t_debug();
    logic [31:0] v;
    setCfg(mk(1,0,0,0,15,0,0,0));
    dbgHalt = 1'b1;
    ticks(3);
    rdReg(3'd6, v); check("R7 halt holds", v, 0);
    setCfg(mk(1,1,0,0,15,0,0,0));
    ticks(3);
    rdReg(3'd6, v); check("R7 debug run counts", v, 3);
    dbgHalt = 1'b0;
  endtask

  task automatic t_flags();
    logic [31:0] v;
    setCfg(mk(1,0,0,0,0,0,0,0));
    wrReg(3'd3, 14'h2);
    rdReg(3'd2, v); check("R8 set alias", v, 2);
    check("R8 irq masked", irqOut, 0);
    wrReg(3'd5, 14'h2);
    check("R8 irq enabled", irqOut, 1);
    wrReg(3'd4, 14'h2);
    rdReg(3'd2, v); check("R8 clear alias", v, 0);
    check("R8 irq cleared", irqOut, 0);
    ticks(8);
    @(negedge clk); tickEn = 1'b1; regWrEn = 1'b1; regAddr = 3'd4; regWrData = 14'h1;
    @(negedge clk); tickEn = 1'b0; regWrEn = 1'b0;
    rdReg(3'd2, v); check("R8 set wins over clear", v, 1);
    wrReg(3'd5, 14'h0);
  endtask

  task automatic t_feedRace();
    logic [31:0] v;
    setCfg(mk(1,0,0,0,0,0,0,0));
    ticks(8);
    @(negedge clk); tickEn = 1'b1; regWrEn = 1'b1; regAddr = 3'd1; regWrData = 14'h1;
    @(negedge clk); tickEn = 1'b0; regWrEn = 1'b0;
    check("R10 no reset on feed race", rstReqOut, 0);
    rdReg(3'd6, v); check("R10 count zero", v, 0);
    rdReg(3'd2, v); check("R10 no timeout flag", v, 0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    logic [13:0] locked;
    locked = mk(1,0,0,0,0,0,0,1);
    setCfg(locked);
    wrReg(3'd0, mk(0,0,0,0,5,0,0,0));
    rdReg(3'd0, v); check("R6 cfg frozen", v, 32'(locked));
    ticks(9);
    check("R6 locked period still active", rstReqOut, 1);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    rdReg(3'd0, v); check("R6 reset clears lock", v, 32'h0F0);
    wrReg(3'd0, mk(1,0,0,0,1,0,0,0));
    rdReg(3'd0, v); check("R6 writable after reset", v, 32'(mk(1,0,0,0,1,0,0,0)));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_timeout();
    t_rstDis();
    t_warn();
    t_window();
    t_clrSrc();
    t_debug();
    t_flags();
    t_feedRace();
    t_lock();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule